// File: doc/BRIEF.md
# Flash Self-Programming Control Register

This block is the byte-wide control and status register that a small microcontroller core uses to program its own on-chip flash. The core writes a command byte while presenting a 16-bit address pointer. The block splits the pointer into a page number and a word-within-page number. It checks the command and launches a single-cycle start strobe towards a flash controller. The strobe carries an operation code: buffer fill, page erase, page write or lock-bit set. The block then holds the command until the controller reports done.

Erase and write operations make the read-while-write section of the flash busy, and the block tells the core fetch path to block reads from that section. The busy state ends in one of two ways: the core issues an explicit re-enable command once the operation is over, or it starts a buffer-fill operation. The block raises a ready interrupt whenever interrupts are allowed and no command is outstanding. A page write issued with a nonzero word field is refused and recorded in a sticky debug flag.

Top module: `selfprog_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `rww_busy`, `irq`, `fl_start` and `dbg_word_err` are 0, and bit 5 and bit 4 always read 0.
- R2: The pointer is decoded as page = `ptr[13:7]` and word = `ptr[6:1]`. `ptr[15:14]` and `ptr[0]` have no effect on any command.
- R3: A write with bit 0 (enable) set and at most one of bits 4..1 set is a command. One cycle after that write, `fl_start` is high for exactly one cycle with `fl_op` = 0 (fill, no bit set), 1 (erase, bit 1), 2 (write, bit 2) or 3 (lock-bit set, bit 3). It carries the decoded page and word. Bit 4 (re-enable) produces no strobe. A write with two or more of bits 4..1 set, or with bit 0 clear, launches nothing.
- R4: Launching an erase or a write sets the busy flag. The busy flag reads on bit 6 and drives `rww_busy`. Fill, lock and re-enable never set it.
- R5: A re-enable command clears the busy flag, and so does launching a fill.
- R6: `irq` is 1 exactly when bit 7 (interrupt enable) is 1, `gie` is 1 and bit 0 reads 0.
- R7: After a launch, bit 0 and the command bit read 1 until `fl_done`. In the cycle after `fl_done` they read 0. A re-enable command leaves bit 0 reading 0.
- R8: A page write whose word field is nonzero launches nothing and sets `dbg_word_err`. That flag stays set until reset.
- R9: While a command is outstanding, a write changes only bit 7. Bits 6..0 stay as they were.
- R10: Every write loads bit 7 from `reg_wdata[7]`, whether or not the write is a valid command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe from the core |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Register read value |
| ptr | input | 16 | Address pointer presented with the write |
| gie | input | 1 | Global interrupt enable from the core |
| irq | output | 1 | Ready interrupt |
| rww_busy | output | 1 | Read-while-write section busy; reads must be blocked |
| fl_start | output | 1 | One-cycle start strobe to the flash controller |
| fl_op | output | 2 | Operation code: 0 fill, 1 erase, 2 write, 3 lock |
| fl_page | output | 7 | Page number of the launched command |
| fl_word | output | 6 | Word number of the launched command |
| fl_done | input | 1 | Flash controller has finished the outstanding command |
| dbg_word_err | output | 1 | Sticky flag: page write refused for a nonzero word field |

## Verification
The hardest state to reach is a write arriving while a command is still outstanding. The bench holds `fl_done` low after an erase launch, writes a new command and a new interrupt-enable value, and checks that only bit 7 moved. It also checks that the busy flag survives until re-enable or fill, and not merely until done. Pointers with bits 15:14 and bit 0 set, a write with a misaligned word, and a write with two command bits set are driven through the vector table. Each of these rows is checked for a launch or for the absence of one.

// File: rtl/selfprog_pkg.sv
package selfprog_pkg;

    localparam int REG_W    = 8;
    localparam int WORD_W   = 6;
    localparam int PAGE_W   = 7;
    localparam int PTR_W    = 16;

    // register bit positions
    localparam int B_EN     = 0;
    localparam int B_ERASE  = 1;
    localparam int B_WRITE  = 2;
    localparam int B_LOCK   = 3;
    localparam int B_REEN   = 4;
    localparam int B_BUSY   = 6;
    localparam int B_IE     = 7;

    typedef enum logic [1:0] {
        OP_FILL  = 2'd0,
        OP_ERASE = 2'd1,
        OP_WRITE = 2'd2,
        OP_LOCK  = 2'd3
    } flash_op_e;

    typedef struct packed {
        logic ie;
        logic reen;
        logic lock;
        logic pgwrt;
        logic pgers;
        logic en;
    } wr_fields_t;

    function automatic wr_fields_t split_write(input logic [REG_W-1:0] d);
        wr_fields_t f;
        f.ie    = d[B_IE];
        f.reen  = d[B_REEN];
        f.lock  = d[B_LOCK];
        f.pgwrt = d[B_WRITE];
        f.pgers = d[B_ERASE];
        f.en    = d[B_EN];
        return f;
    endfunction

    function automatic logic op_sets_busy(input flash_op_e op);
        return (op == OP_ERASE) || (op == OP_WRITE);
    endfunction

endpackage

// File: rtl/selfprog_addr_split.sv
module selfprog_addr_split #(
    parameter int PTR_W  = 16,
    parameter int WORD_W = 6,
    parameter int PAGE_W = 7
) (
    input  logic [PTR_W-1:0]  ptr,
    output logic [PAGE_W-1:0] page,
    output logic [WORD_W-1:0] word
);
    localparam int WORD_LSB = 1;
    localparam int PAGE_LSB = WORD_LSB + WORD_W;
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

    assign word = ptr[PAGE_LSB-1:WORD_LSB];
    assign page = ptr[PAGE_MSB:PAGE_LSB];

    logic unused_ptr_bits;
    generate
        if (PAGE_MSB < PTR_W - 1) begin : g_high
            assign unused_ptr_bits = ^{ptr[PTR_W-1:PAGE_MSB+1], ptr[0]};
        end else begin : g_nohigh
            assign unused_ptr_bits = ptr[0];
        end
    endgenerate
endmodule

// File: rtl/selfprog_cmd_decode.sv
module selfprog_cmd_decode
    import selfprog_pkg::*;
#(
    parameter int WORD_W = 6
) (
    input  wr_fields_t        f,
    input  logic [WORD_W-1:0] word,
    output logic              valid,
    output logic              is_reen,
    output logic              word_err,
    output logic              flash_go,
    output flash_op_e         op
);
    logic [3:0] cmd_bits;

    always_comb begin
        cmd_bits = {f.reen, f.lock, f.pgwrt, f.pgers};
        valid    = f.en && ($countones(cmd_bits) <= 1);
        is_reen  = valid && f.reen;
        word_err = valid && f.pgwrt && (word != '0);
        flash_go = valid && !f.reen && !word_err;
        if (f.pgers)      op = OP_ERASE;
        else if (f.pgwrt) op = OP_WRITE;
        else if (f.lock)  op = OP_LOCK;
        else              op = OP_FILL;
    end
endmodule

// File: rtl/selfprog_rww_track.sv
module selfprog_rww_track (
    input  logic clk,
    input  logic rst,
    input  logic set_busy,
    input  logic clr_busy,
    output logic busy
);
    always_ff @(posedge clk) begin
        if (rst)           busy <= 1'b0;
        else if (set_busy) busy <= 1'b1;
        else if (clr_busy) busy <= 1'b0;
    end
endmodule

// File: rtl/selfprog_ctrl.sv
module selfprog_ctrl
    import selfprog_pkg::*;
#(
    parameter int PTR_W  = selfprog_pkg::PTR_W,
    parameter int WORD_W = selfprog_pkg::WORD_W,
    parameter int PAGE_W = selfprog_pkg::PAGE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr_en,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              gie,
    output logic              irq,
    output logic              rww_busy,
    output logic              fl_start,
    output logic [1:0]        fl_op,
    output logic [PAGE_W-1:0] fl_page,
    output logic [WORD_W-1:0] fl_word,
    input  logic              fl_done,
    output logic              dbg_word_err
);
    wr_fields_t        fields;
    logic [PAGE_W-1:0] dec_page;
    logic [WORD_W-1:0] dec_word;
    logic              valid, is_reen, word_err, flash_go;
    flash_op_e         dec_op;

    logic              ie_q, en_q, ers_q, wrt_q, lck_q, pend_q, start_q, err_q;
    flash_op_e         op_q;
    logic [PAGE_W-1:0] page_q;
    logic [WORD_W-1:0] word_q;
    logic              accept, set_busy, clr_busy, busy;

    assign fields = split_write(reg_wdata);

    selfprog_addr_split #(.PTR_W(PTR_W), .WORD_W(WORD_W), .PAGE_W(PAGE_W)) u_addr (
        .ptr  (ptr),
        .page (dec_page),
        .word (dec_word)
    );

    selfprog_cmd_decode #(.WORD_W(WORD_W)) u_dec (
        .f        (fields),
        .word     (dec_word),
        .valid    (valid),
        .is_reen  (is_reen),
        .word_err (word_err),
        .flash_go (flash_go),
        .op       (dec_op)
    );

    assign accept   = reg_wr_en && !pend_q;
    assign set_busy = accept && flash_go && op_sets_busy(dec_op);
    assign clr_busy = accept && (is_reen || (flash_go && dec_op == OP_FILL));

    selfprog_rww_track u_rww (
        .clk      (clk),
        .rst      (rst),
        .set_busy (set_busy),
        .clr_busy (clr_busy),
        .busy     (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q    <= 1'b0;
            en_q    <= 1'b0;
            ers_q   <= 1'b0;
            wrt_q   <= 1'b0;
            lck_q   <= 1'b0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
            err_q   <= 1'b0;
            op_q    <= OP_FILL;
            page_q  <= '0;
            word_q  <= '0;
        end else begin
            start_q <= 1'b0;
            if (reg_wr_en) ie_q <= fields.ie;
            if (pend_q && fl_done) begin
                pend_q <= 1'b0;
                en_q   <= 1'b0;
                ers_q  <= 1'b0;
                wrt_q  <= 1'b0;
                lck_q  <= 1'b0;
            end else if (accept && flash_go) begin
                pend_q  <= 1'b1;
                start_q <= 1'b1;
                en_q    <= 1'b1;
                ers_q   <= fields.pgers;
                wrt_q   <= fields.pgwrt;
                lck_q   <= fields.lock;
                op_q    <= dec_op;
                page_q  <= dec_page;
                word_q  <= dec_word;
            end
            if (accept && word_err) err_q <= 1'b1;
        end
    end

    logic unused_wbits;
    assign unused_wbits = ^{reg_wdata[6:5], valid};

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[B_IE]    = ie_q;
        reg_rdata[B_BUSY]  = busy;
        reg_rdata[B_LOCK]  = lck_q;
        reg_rdata[B_WRITE] = wrt_q;
        reg_rdata[B_ERASE] = ers_q;
        reg_rdata[B_EN]    = en_q;
    end

    assign irq          = ie_q && gie && !en_q;
    assign rww_busy     = busy;
    assign fl_start     = start_q;
    assign fl_op        = op_q;
    assign fl_page      = page_q;
    assign fl_word      = word_q;
    assign dbg_word_err = err_q;
endmodule

// File: rtl/selfprog_ctrl_chk.sv
module selfprog_ctrl_chk #(
    parameter int WORD_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        reg_rdata,
    input logic              gie,
    input logic              irq,
    input logic              rww_busy,
    input logic              fl_start,
    input logic [1:0]        fl_op,
    input logic [WORD_W-1:0] fl_word,
    input logic              fl_done,
    input logic              dbg_word_err
);
    // R4: an erase or write strobe is always accompanied by busy
    a_r4_busy_on_launch: assert property (@(posedge clk) disable iff (rst)
        (fl_start && (fl_op == 2'd1 || fl_op == 2'd2)) |-> rww_busy);

    // R5: a fill strobe leaves the section free
    a_r5_fill_frees: assert property (@(posedge clk) disable iff (rst)
        (fl_start && fl_op == 2'd0) |-> !rww_busy);

    // R6: no interrupt while a command is outstanding or interrupts are off
    a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!reg_rdata[0] && gie && reg_rdata[7]));

    // R3: strobe lasts one cycle
    a_r3_single_strobe: assert property (@(posedge clk) disable iff (rst)
        fl_start |=> !fl_start);

    // R8: a launched page write always has word zero
    a_r8_write_aligned: assert property (@(posedge clk) disable iff (rst)
        (fl_start && fl_op == 2'd2) |-> (fl_word == '0));

    // R8: error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        dbg_word_err |=> dbg_word_err);

    // R9: outstanding command freezes bits 6..0 until done
    a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && !fl_done) |=> $stable(reg_rdata[6:0]));

    // R1: reserved positions read zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[5:4] == 2'b00);
endmodule

bind selfprog_ctrl selfprog_ctrl_chk #(.WORD_W(WORD_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_rdata    (reg_rdata),
    .gie          (gie),
    .irq          (irq),
    .rww_busy     (rww_busy),
    .fl_start     (fl_start),
    .fl_op        (fl_op),
    .fl_word      (fl_word),
    .fl_done      (fl_done),
    .dbg_word_err (dbg_word_err)
);

// File: tb/sim_selfprog_ctrl.sv
`timescale 1ns/1ps
module sim_selfprog_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [15:0] ptr = '0;
    logic        gie = 1'b0;
    logic        irq, rww_busy, fl_start, fl_done, dbg_word_err;
    logic [1:0]  fl_op;
    logic [6:0]  fl_page;
    logic [5:0]  fl_word;
    int          errors = 0;
    int          checks = 0;

    assign fl_done = done_drv;
    logic done_drv = 1'b0;

    always #2.5 clk = ~clk;

    selfprog_ctrl u0 (
        .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ptr(ptr), .gie(gie), .irq(irq),
        .rww_busy(rww_busy), .fl_start(fl_start), .fl_op(fl_op),
        .fl_page(fl_page), .fl_word(fl_word), .fl_done(fl_done),
        .dbg_word_err(dbg_word_err)
    );

    // row: wdata, ptr, start, op, page, word, busy after, err after
    localparam int NV = 10;
    localparam logic [41:0] VEC [NV] = '{
        {8'h03, 16'h0080, 1'b1, 2'd1, 7'd1,   6'd0,  1'b1, 1'b0}, // R3 R4 erase
        {8'h11, 16'h0000, 1'b0, 2'd0, 7'd0,   6'd0,  1'b0, 1'b0}, // R5 re-enable
        {8'h05, 16'h0100, 1'b1, 2'd2, 7'd2,   6'd0,  1'b1, 1'b0}, // R3 R4 write
        {8'h01, 16'h000A, 1'b1, 2'd0, 7'd0,   6'd5,  1'b0, 1'b0}, // R5 fill frees
        {8'h07, 16'h0100, 1'b0, 2'd0, 7'd0,   6'd0,  1'b0, 1'b0}, // R3 two bits
        {8'h05, 16'h0102, 1'b0, 2'd0, 7'd0,   6'd0,  1'b0, 1'b1}, // R8 misaligned
        {8'h09, 16'h0000, 1'b1, 2'd3, 7'd0,   6'd0,  1'b0, 1'b1}, // R3 lock
        {8'h03, 16'hC081, 1'b1, 2'd1, 7'd1,   6'd0,  1'b1, 1'b1}, // R2 ignored bits
        {8'h02, 16'h0000, 1'b0, 2'd0, 7'd0,   6'd0,  1'b1, 1'b1}, // R3 no enable
        {8'h01, 16'h3FFE, 1'b1, 2'd0, 7'd127, 6'd63, 1'b0, 1'b1}  // R2 R5 top page
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d, input logic [15:0] p);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wdata = d; ptr = p;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        done_drv = 1'b1;
        @(negedge clk);
        done_drv = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", reg_rdata, 8'h00);
        chk("R1 outs", {irq, rww_busy, fl_start, dbg_word_err}, 4'b0);

        for (int i = 0; i < NV; i++) begin
            logic [41:0] v;
            v = VEC[i];
            wr(v[41:34], v[33:18]);
            chk($sformatf("R3 row%0d start", i), fl_start, v[17]);
            if (v[17]) begin
                chk($sformatf("R3 row%0d op", i), fl_op, v[16:15]);
                chk($sformatf("R2 row%0d page", i), fl_page, v[14:8]);
                chk($sformatf("R2 row%0d word", i), fl_word, v[7:2]);
                chk($sformatf("R7 row%0d en held", i), reg_rdata[0], 1'b1);
                done_pulse();
            end
            chk($sformatf("R7 row%0d en clear", i), reg_rdata[0], 1'b0);
            chk($sformatf("R4 row%0d busy bit", i), reg_rdata[6], v[1]);
            chk($sformatf("R4 row%0d busy pin", i), rww_busy, v[1]);
            chk($sformatf("R8 row%0d err", i), dbg_word_err, v[0]);
        end

        // R6 / R10 interrupt enable and gating
        gie = 1'b1;
        wr(8'h80, 16'h0);
        chk("R10 ie loaded", reg_rdata[7], 1'b1);
        chk("R6 irq on", irq, 1'b1);
        gie = 1'b0;
        @(negedge clk);
        chk("R6 irq off gie", irq, 1'b0);
        gie = 1'b1;

        // R9 writes while outstanding: only bit 7 moves
        wr(8'h83, 16'h0200);
        chk("R4 erase busy", reg_rdata, 8'hC3);
        chk("R6 irq while pending", irq, 1'b0);
        wr(8'h05, 16'h0000);
        chk("R9 ignored write", reg_rdata, 8'h43);
        chk("R9 no strobe", fl_start, 1'b0);
        wr(8'h91, 16'h0000);
        chk("R9 reen ignored", reg_rdata, 8'hC3);
        done_pulse();
        chk("R7 done clears", reg_rdata, 8'hC0);
        chk("R6 irq after done", irq, 1'b1);
        // R5 busy survives done, cleared by re-enable
        wr(8'h11, 16'h0000);
        chk("R5 reen clears", reg_rdata, 8'h00);
        chk("R10 ie from reen write", irq, 1'b0);

        // R1 reset mid-state
        wr(8'h05, 16'h0004);
        chk("R8 err set", dbg_word_err, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset err", dbg_word_err, 1'b0);
        chk("R1 reset rdata", reg_rdata, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule